// File: doc/BRIEF.md
# MDIO Management Master

This block reads and writes registers in an external Ethernet PHY over a two-wire management bus. It drives a management clock (MDC) and a bidirectional data line (MDIO). The data line leaves the block as an output value with an output enable, and comes back as a separate input. A request is a one-cycle start strobe together with a read/write select, a 5-bit PHY address, a register offset and 16 bits of write data. The block returns 16-bit read data, a busy level, a one-cycle done pulse and an error flag for offsets that are out of range.

Every frame has 64 MDC pulses. It opens with a preamble of 32 ones. A write then drives the frame marker, opcode, addresses, a fixed turnaround pattern and the data word. A read drives the marker, opcode and addresses. It then releases the line for one turnaround pulse, samples 16 data bits while MDC is high, and gives one idle pulse before it finishes. The length of each MDC phase is a number of system clocks taken from an input. That number is captured when a request is accepted.

Top module: `mdio_master`

## Requirements
- R1: Each frame starts with 32 MDC pulses during which MDIO is driven to 1. All fields are sent most significant bit first. MDIO changes only while MDC is low, and is stable for the whole of each high phase.
- R2: After the preamble, a write drives 32 bits in this order: frame marker `01`, opcode `01`, PHY address[4:0], offset[4:0], turnaround `10`, write data[15:0].
- R3: After the preamble, a read drives 14 bits in this order: frame marker `01`, opcode `10`, PHY address[4:0], offset[4:0].
- R4: A read drops the output enable after its 46th pulse, and the enable stays low for the remaining 18 pulses. A write keeps the enable high for all 64 pulses.
- R5: A read ignores the line during the turnaround pulse (pulse 47). It samples MDIO at the end of the high phase of pulses 48 to 63, most significant bit first, and presents the 16-bit result on the read data output in the done cycle.
- R6: Both reads and writes produce exactly 64 MDC pulses. For a read, the last of these is an idle pulse after the 16th data bit.
- R7: A start whose offset is larger than MAX_REG (31 by default) is rejected. The error flag is high from the next cycle on, busy stays low, and MDC and the output enable stay low. The flag clears when the next request is accepted.
- R8: Each MDC high phase and each low phase lasts max(half_period, 2) system clocks. The half_period value is captured at acceptance.
- R9: Busy rises in the cycle after an accepted start and stays high for 128 × max(half_period, 2) cycles. Done is then high for exactly one cycle, with busy already low.
- R10: A start strobe raised while busy has no effect on the current frame and does not start a second frame.
- R11: The read data output changes only in the done cycle of a read. It holds its value through later writes and while a read is in progress.
- R12: After reset, busy, done, error, MDC, output enable and read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_ofs_i | input | OFS_W (8) | Register offset; values above MAX_REG are rejected |
| wdata_i | input | 16 | Write data |
| half_period_i | input | DIV_W (8) | MDC phase length in system clocks (values below 2 act as 2) |
| rdata_o | output | 16 | Data from the last completed read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| err_o | output | 1 | Last rejected request had an out-of-range offset |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Sampled MDIO input |

## Verification
The assertions assume that the PHY-side input changes only while MDC is low and that request fields are meaningful only in the strobe cycle. They also assume that phase lengths below 2 are clamped, so that MDC never toggles on two consecutive clocks. The bench's PHY model changes MDIO one clock after each falling edge of MDC, which keeps it well clear of the sampling point. Stray strobes during a frame carry deliberately different fields, so that any leak into the running frame or any second frame shows up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int FRAME_BITS = 64;
    localparam int SLOT_W     = $clog2(FRAME_BITS);
    localparam int TA_SLOT    = PRE_BITS + HDR_BITS;
    localparam int RD_FIRST   = TA_SLOT + 1;
    localparam int RD_LAST    = RD_FIRST + DATA_W - 1;
    localparam int LAST_SLOT  = FRAME_BITS - 1;

    localparam logic [1:0] MARK_SOF = 2'b01;
    localparam logic [1:0] CODE_RD  = 2'b10;
    localparam logic [1:0] CODE_WR  = 2'b01;
    localparam logic [1:0] TURN_WR  = 2'b10;

    // Full 64-bit serial image, transmitted from bit 63 downward.
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic              rd,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rg,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0]        code;
        logic [1:0]        turn;
        logic [DATA_W-1:0] body;
        code = rd ? CODE_RD : CODE_WR;
        turn = rd ? 2'b00 : TURN_WR;
        body = rd ? '0 : wd;
        return {{PRE_BITS{1'b1}}, MARK_SOF, code, phy, rg, turn, body};
    endfunction

endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             fall_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } ph_t;

    ph_t  st_d, st_q;
    logic ph_end;

    always_comb begin
        ph_end = (st_q.cnt == half_i - DIV_W'(1));
        st_d   = st_q;
        if (!run_i) begin
            st_d = '0;
        end else if (ph_end) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        fall_o = run_i && ph_end && st_q.mdc;
        mdc_o  = st_q.mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(st_q.mdc) |=> $stable(st_q.mdc)); // R8

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  rd_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  fall_i,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe_o,
    output logic                  last_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam logic [SLOT_W-1:0] S_TA    = SLOT_W'(TA_SLOT);
    localparam logic [SLOT_W-1:0] S_FIRST = SLOT_W'(RD_FIRST);
    localparam logic [SLOT_W-1:0] S_LAST  = SLOT_W'(RD_LAST);
    localparam logic [SLOT_W-1:0] S_END   = SLOT_W'(LAST_SLOT);

    typedef struct packed {
        logic [FRAME_BITS-1:0] frame;
        logic [SLOT_W-1:0]     slot;
        logic                  active;
        logic                  rd;
        logic [DATA_W-1:0]     rsh;
    } eng_t;

    eng_t st_d, st_q;
    logic drive;

    always_comb begin
        st_d   = st_q;
        drive  = st_q.active && (!st_q.rd || st_q.slot < S_TA);
        last_o = st_q.active && fall_i && (st_q.slot == S_END);
        if (load_i) begin
            st_d.frame  = frame_i;
            st_d.slot   = '0;
            st_d.active = 1'b1;
            st_d.rd     = rd_i;
        end else if (st_q.active && fall_i) begin
            if (st_q.rd && st_q.slot >= S_FIRST && st_q.slot <= S_LAST)
                st_d.rsh = {st_q.rsh[DATA_W-2:0], mdio_i};
            st_d.frame = {st_q.frame[FRAME_BITS-2:0], 1'b0};
            if (st_q.slot == S_END) st_d.active = 1'b0;
            else                    st_d.slot   = st_q.slot + SLOT_W'(1);
        end
        mdio_o    = drive ? st_q.frame[FRAME_BITS-1] : 1'b0;
        mdio_oe_o = drive;
        rdata_o   = st_q.rsh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int OFS_W   = 8,
    parameter int MAX_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [PHY_W-1:0]  phy_addr_i,
    input  logic [OFS_W-1:0]  reg_ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DIV_W-1:0]  half_period_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);

    localparam logic [DIV_W-1:0] MIN_HALF  = DIV_W'(2);
    localparam logic [OFS_W-1:0] OFS_LIMIT = OFS_W'(MAX_REG);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              err;
        logic              rd;
        logic [DIV_W-1:0]  half;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                  accept, reject, bad_ofs;
    logic                  fall, last;
    logic [DATA_W-1:0]     eng_rdata;
    logic [FRAME_BITS-1:0] frame;

    always_comb begin
        bad_ofs = reg_ofs_i > OFS_LIMIT;
        accept  = start_i && !st_q.busy && !bad_ofs;
        reject  = start_i && !st_q.busy && bad_ofs;
        frame   = make_frame(rd_i, phy_addr_i, reg_ofs_i[REG_W-1:0], wdata_i);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.err  = 1'b0;
            st_d.rd   = rd_i;
            st_d.half = (half_period_i < MIN_HALF) ? MIN_HALF : half_period_i;
        end else if (reject) begin
            st_d.err = 1'b1;
        end
        if (last) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (st_q.rd) st_d.rdata = eng_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.busy),
        .half_i (st_q.half),
        .mdc_o  (mdc_o),
        .fall_o (fall)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .rd_i      (rd_i),
        .frame_i   (frame),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .last_o    (last),
        .rdata_o   (eng_rdata)
    );

    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign err_o   = st_q.err;
    assign rdata_o = st_q.rdata;

    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o); // R7
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> (!mdc_o && !mdio_oe_o)); // R7
    AST_MDIO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_o) |-> done_o); // R11

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [7:0]  reg_ofs_i = '0;
    logic [15:0] wdata_i = '0;
    logic [7:0]  half_period_i = 8'd2;
    logic [15:0] rdata_o;
    logic        busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i = 1'b1;

    always #2 clk = ~clk;

    mdio_master #(.DIV_W(8), .OFS_W(8), .MAX_REG(31)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_ofs_i(reg_ofs_i), .wdata_i(wdata_i),
        .half_period_i(half_period_i), .rdata_o(rdata_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
        .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // PHY model: records driven bits on MDC rise, answers reads after MDC fall.
    logic [63:0] cap = '0;
    logic [63:0] oeh = '0;
    int          rises = 0;
    int          falls = 0;
    logic [15:0] resp = '0;

    always @(posedge mdc_o) begin
        cap = {cap[62:0], mdio_oe_o ? mdio_o : 1'b0};
        oeh = {oeh[62:0], mdio_oe_o};
        rises++;
    end

    always begin : phy_answer
        int f;
        @(negedge mdc_o);
        falls++;
        f = falls;
        #1;
        if (f >= 47 && f <= 62) mdio_i = resp[62-f];
        else if (f == 46)       mdio_i = 1'b0;
        else                    mdio_i = 1'b1;
    end

    // Scoreboard
    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe;
        logic [15:0] rdata;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] last_rd = '0;

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R10 done without request", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(cap === e.frame, "R1 R2 R3 frame bits", cap, e.frame);
                check(oeh === e.oe, "R4 drive window", oeh, e.oe);
                check(rises == 64, "R6 MDC pulse count", 64'(rises), 64'd64);
                check(rdata_o === e.rdata, "R5 read data", 64'(rdata_o), 64'(e.rdata));
            end
        end
    end

    task automatic xfer(input bit rd, input logic [4:0] phy, input logic [7:0] ofs,
                        input logic [15:0] wd, input logic [15:0] rsp,
                        input int half, input bit poke);
        exp_t        e;
        int          h, bcnt, hcnt, cyc;
        logic [15:0] prev;
        h    = (half < 2) ? 2 : half;
        bcnt = 0; hcnt = 0; cyc = 0;
        prev = last_rd;
        e.frame = rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ofs[4:0], 18'b0}
                     : {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ofs[4:0], 2'b10, wd};
        e.oe    = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        if (rd) last_rd = rsp;
        e.rdata = last_rd;
        sbq.push_back(e);
        resp  = rsp;
        rises = 0;
        falls = 0;
        @(negedge clk);
        start_i = 1'b1; rd_i = rd; phy_addr_i = phy; reg_ofs_i = ofs;
        wdata_i = wd; half_period_i = 8'(half);
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) check(!err_o, "R7 error cleared on accept", 64'(err_o), 64'd0);
            if (cyc == 100) check(rdata_o === prev, "R11 read data held in frame",
                                  64'(rdata_o), 64'(prev));
            if (busy_o) bcnt++;
            if (mdc_o)  hcnt++;
            if (done_o) break;
            start_i = poke && (cyc == 40);
            if (poke && cyc == 40) begin
                rd_i = ~rd; phy_addr_i = ~phy; reg_ofs_i = 8'd7; wdata_i = ~wd;
                half_period_i = 8'd9;
            end
        end
        start_i = 1'b0;
        check(bcnt == 128*h, "R9 busy length", 64'(bcnt), 64'(128*h));
        check(hcnt == 64*h, "R8 MDC high time", 64'(hcnt), 64'(64*h));
        repeat (3) begin
            @(negedge clk);
            check(!done_o && !busy_o, "R10 single frame and done pulse",
                  {62'd0, done_o, busy_o}, 64'd0);
        end
        check(rdata_o === last_rd, "R11 read data held after done",
              64'(rdata_o), 64'(last_rd));
    endtask

    task automatic bad_req(input logic [7:0] ofs);
        rises = 0;
        @(negedge clk);
        start_i = 1'b1; rd_i = 1'b1; reg_ofs_i = ofs; half_period_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o === 1'b1, "R7 error flag on bad offset", 64'(err_o), 64'd1);
        repeat (20) begin
            @(negedge clk);
            check(!busy_o && !mdio_oe_o && !mdc_o, "R7 no activity after reject",
                  {61'd0, busy_o, mdio_oe_o, mdc_o}, 64'd0);
        end
        check(rises == 0, "R7 no MDC pulse", 64'(rises), 64'd0);
        check(err_o === 1'b1, "R7 error flag held", 64'(err_o), 64'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check({busy_o, done_o, err_o, mdc_o, mdio_oe_o} === 5'b0, "R12 reset outputs",
              64'({busy_o, done_o, err_o, mdc_o, mdio_oe_o}), 64'd0);
        check(rdata_o === 16'h0, "R12 reset read data", 64'(rdata_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !mdc_o, "R12 idle after reset", {62'd0, busy_o, mdc_o}, 64'd0);

        xfer(1'b0, 5'h11, 8'd3,  16'hBEEF, 16'h0000, 2, 1'b0);
        xfer(1'b1, 5'h02, 8'd31, 16'h0000, 16'hA5C3, 3, 1'b0);
        bad_req(8'd40);
        bad_req(8'd32);
        xfer(1'b0, 5'h1F, 8'd0,  16'h0001, 16'h0000, 0, 1'b1);
        xfer(1'b1, 5'h00, 8'd17, 16'h0000, 16'h8001, 5, 1'b0);
        xfer(1'b1, 5'h15, 8'd9,  16'h0000, 16'h5A5A, 1, 1'b1);
        xfer(1'b0, 5'h0A, 8'd30, 16'h8000, 16'h0000, 4, 1'b0);

        check(sbq.size() == 0, "R10 all frames completed", 64'(sbq.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule